// File: doc/BRIEF.md
# Reloading Countdown Timer Channel

This block is one channel of a down-counting timer. Software reaches it through a simple register port. It holds a load value, a live counter, a control word and a clear address. While enabled, the counter steps down by one on each pulse from whichever of two tick-enable inputs the control word selects. When the counter is already zero and another tick arrives, that is an underflow. An underflow raises a level interrupt. It also either reloads the counter from the load register (periodic mode) or wraps it to all-ones (free-running mode).

The interrupt stays high until software writes any value to the clear address. Writing the load register also places the new value in the counter at once, so a fresh countdown starts without waiting for an underflow. One parameter sets the counter width, so the same code serves both the narrow 16-bit channels and the wide 32-bit ones. A two-stage synchronizer inside the block turns the asynchronous reset input into a reset whose release is synchronous to the clock.

Top module: `cdt_channel`

## Requirements
- R1: After reset the load register, counter and control word all read 0, and `irq_o` is low.
- R2: A write to byte offset 0x0 (load) stores the value in the load register and in the counter in the same clock edge. Both read back the new value afterwards.
- R3: With control bit 7 set, the counter decreases by one on each pulse of the selected tick. Control bit 3 = 1 selects `tick_fast_i` and bit 3 = 0 selects `tick_slow_i`. Pulses on the other tick input have no effect.
- R4: With control bit 7 clear, tick pulses on either input leave the counter unchanged and raise no interrupt.
- R5: In periodic mode (control bit 6 = 1), a selected tick while the counter is 0 reloads the counter from the load register and sets `irq_o`.
- R6: In free-running mode (control bit 6 = 0), a selected tick while the counter is 0 sets the counter to all-ones and sets `irq_o`.
- R7: A write of any data to byte offset 0xC clears `irq_o` on the next edge. If an underflow happens in the same cycle as that write, `irq_o` stays high.
- R8: Reading offset 0x8 returns bits 7, 6 and 3 as last written, with all other bits 0. Reading offset 0xC returns 0. Reading offset 0x4 returns the live counter.
- R9: Only the low CNT_W bits of a load write are kept. The counter and load values read back zero-extended to 32 bits, and all-ones in free-running mode means CNT_W ones.
- R10: If a load write and a selected tick fall in the same cycle, the load value wins and no underflow or interrupt results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| tick_slow_i | input | 1 | Slow tick enable, one clock wide per tick |
| tick_fast_i | input | 1 | Fast tick enable (about 508 kHz rate), one clock wide per tick |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address within the channel; bits 3:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, available in the same cycle |
| irq_o | output | 1 | Level interrupt, set on underflow and cleared by a write to 0xC |

## Verification
On every cycle the assertions check the counter's step rules: hold while disabled, one step down per selected tick, reload or wrap on underflow, and the load-write override. They also check that an underflow always sets the interrupt, and that the interrupt falls only after a clear write that had no competing underflow. Only the bench scenarios show the register-level effects: which tick input the select bit actually routes, the read-back masking of the control word and the clear address, and the truncation and zero-extension in a 16-bit instance. The two same-cycle races are shown at the ports only in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register select taken from address bits [3:2]
  localparam logic [1:0] SEL_LOAD  = 2'd0;  // byte offset 0x0
  localparam logic [1:0] SEL_VALUE = 2'd1;  // byte offset 0x4
  localparam logic [1:0] SEL_CTRL  = 2'd2;  // byte offset 0x8
  localparam logic [1:0] SEL_CLEAR = 2'd3;  // byte offset 0xC

  // Control word bit positions
  localparam int unsigned BIT_RUN      = 7;
  localparam int unsigned BIT_PERIODIC = 6;
  localparam int unsigned BIT_FASTSEL  = 3;

  typedef struct packed {
    logic run;
    logic periodic;
    logic fastsel;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output tmr_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  load_new_o,
  output logic              load_wr_o,
  output logic              clr_wr_o
);

  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic [1:0]       sel;
  logic             ctrl_wr;
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] load_ext, cnt_ext, ctrl_ext;

  assign sel        = addr_i[3:2];
  assign load_wr_o  = wr_en_i && (sel == SEL_LOAD);
  assign ctrl_wr    = wr_en_i && (sel == SEL_CTRL);
  assign clr_wr_o   = wr_en_i && (sel == SEL_CLEAR);
  assign load_new_o = wdata_i[CNT_W-1:0];

  // next-state
  always_comb begin
    load_d = load_q;
    ctrl_d = ctrl_q;
    if (load_wr_o) begin
      load_d = load_new_o;
    end
    if (ctrl_wr) begin
      ctrl_d.run      = wdata_i[BIT_RUN];
      ctrl_d.periodic = wdata_i[BIT_PERIODIC];
      ctrl_d.fastsel  = wdata_i[BIT_FASTSEL];
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_wr_o) load_q <= load_d;
      if (ctrl_wr)   ctrl_q <= ctrl_d;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign load_ext = {{PAD_W{1'b0}}, load_q};
      assign cnt_ext  = {{PAD_W{1'b0}}, cnt_i};
    end else begin : g_nopad
      assign load_ext = load_q;
      assign cnt_ext  = cnt_i;
    end
  endgenerate

  always_comb begin
    ctrl_ext               = '0;
    ctrl_ext[BIT_RUN]      = ctrl_q.run;
    ctrl_ext[BIT_PERIODIC] = ctrl_q.periodic;
    ctrl_ext[BIT_FASTSEL]  = ctrl_q.fastsel;
  end

  // read mux
  always_comb begin
    unique case (sel)
      SEL_LOAD:  rdata_o = load_ext;
      SEL_VALUE: rdata_o = cnt_ext;
      SEL_CTRL:  rdata_o = ctrl_ext;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;

endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
  input  logic run_i,
  input  logic fastsel_i,
  input  logic tick_slow_i,
  input  logic tick_fast_i,
  output logic tick_o
);

  logic src;

  always_comb begin
    src    = fastsel_i ? tick_fast_i : tick_slow_i;
    tick_o = run_i && src;
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_new_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state: load write overrides any tick in the same cycle
  always_comb begin
    cnt_d       = cnt_q;
    underflow_o = 1'b0;
    if (load_wr_i) begin
      cnt_d = load_new_i;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        underflow_o = 1'b1;
        cnt_d       = periodic_i ? load_i : '1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_en = load_wr_i || tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  logic irq_q, irq_d;

  // set has priority so a coincident event is kept
  always_comb begin
    irq_d = irq_q;
    if (clr_i) irq_d = 1'b0;
    if (set_i) irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (set_i || clr_i) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_slow_i,
  input  logic        tick_fast_i,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  logic             rst_n_sync;
  tmr_ctrl_t        ctrl;
  logic             run_en;
  logic             periodic_en;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] load_new;
  logic             load_wr;
  logic             clr_wr;
  logic             tick_gated;
  logic [CNT_W-1:0] cnt_q;
  logic             underflow;

  tmr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  tmr_regfile #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .rdata_o    (rdata_o),
    .ctrl_o     (ctrl),
    .load_o     (load_q),
    .load_new_o (load_new),
    .load_wr_o  (load_wr),
    .clr_wr_o   (clr_wr)
  );

  assign run_en      = ctrl.run;
  assign periodic_en = ctrl.periodic;

  tmr_tick_sel u_tick_sel (
    .run_i       (run_en),
    .fastsel_i   (ctrl.fastsel),
    .tick_slow_i (tick_slow_i),
    .tick_fast_i (tick_fast_i),
    .tick_o      (tick_gated)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .tick_i      (tick_gated),
    .periodic_i  (periodic_en),
    .load_wr_i   (load_wr),
    .load_new_i  (load_new),
    .load_i      (load_q),
    .cnt_o       (cnt_q),
    .underflow_o (underflow)
  );

  tmr_irq_latch u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .set_i  (underflow),
    .clr_i  (clr_wr),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/cdt_channel_chk.sv
module cdt_channel_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             run,
  input logic             periodic,
  input logic             tick,
  input logic             load_wr,
  input logic             clr_wr,
  input logic [CNT_W-1:0] load_new,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cnt,
  input logic             irq
);

  logic uf_seen;
  assign uf_seen = tick && !load_wr && (cnt == '0);

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_wr |=> (cnt == $past(load_new)));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick && !load_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_hold_off_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run && !load_wr) |=> $stable(cnt));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (uf_seen && periodic) |=> (cnt == $past(load_q)));

  assert_irq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    uf_seen |=> irq);

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (uf_seen && !periodic) |=> (&cnt));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_wr && !uf_seen) |=> !irq);

  assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_wr));

endmodule

bind cdt_channel cdt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_sync),
  .run      (run_en),
  .periodic (periodic_en),
  .tick     (tick_gated),
  .load_wr  (load_wr),
  .clr_wr   (clr_wr),
  .load_new (load_new),
  .load_q   (load_q),
  .cnt      (cnt_q),
  .irq      (irq_o)
);

// File: tb/test_cdt_channel.sv
module test_cdt_channel;

  logic        clk;
  logic        rst_n;
  logic        tick_slow;
  logic        tick_fast;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] rdata_w16;
  logic        irq_w16;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [3:0] A_LOAD = 4'h0;
  localparam logic [3:0] A_VAL  = 4'h4;
  localparam logic [3:0] A_CTRL = 4'h8;
  localparam logic [3:0] A_CLR  = 4'hC;

  cdt_channel #(.CNT_W(32)) i_cdt_channel (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(tick_slow), .tick_fast_i(tick_fast),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  cdt_channel #(.CNT_W(16)) i_cdt_channel_w16 (
    .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(tick_slow), .tick_fast_i(tick_fast),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_w16), .irq_o(irq_w16)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input bit fast);
    @(negedge clk);
    if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(A_LOAD, v); chk("R1 load", v, 32'h0);
    bus_rd(A_VAL, v);  chk("R1 value", v, 32'h0);
    bus_rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    bus_wr(A_LOAD, 32'd5);
    bus_rd(A_VAL, v);  chk("R2 value", v, 32'd5);
    bus_rd(A_LOAD, v); chk("R2 load", v, 32'd5);
  endtask

  task automatic t_count();
    logic [31:0] v;
    bus_wr(A_CTRL, 32'hC8);
    pulse(0);
    bus_rd(A_VAL, v); chk("R3 slow ignored when fast selected", v, 32'd5);
    pulse(1); pulse(1);
    bus_rd(A_VAL, v); chk("R3 two fast ticks", v, 32'd3);
    bus_wr(A_CTRL, 32'hC0);
    pulse(1);
    bus_rd(A_VAL, v); chk("R3 fast ignored when slow selected", v, 32'd3);
    pulse(0);
    bus_rd(A_VAL, v); chk("R3 slow tick", v, 32'd2);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    bus_wr(A_LOAD, 32'd1);
    bus_wr(A_CTRL, 32'hC0);
    pulse(0);
    bus_rd(A_VAL, v); chk("R5 reach zero", v, 32'd0);
    chk("R5 no irq at zero", {31'b0, irq}, 32'h0);
    pulse(0);
    bus_rd(A_VAL, v); chk("R5 reload", v, 32'd1);
    chk("R5 irq set", {31'b0, irq}, 32'h1);
    pulse(0);
    chk("R5 irq held", {31'b0, irq}, 32'h1);
    bus_wr(A_CLR, 32'h0);
    chk("R7 clear", {31'b0, irq}, 32'h0);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_freerun();
    logic [31:0] v;
    bus_wr(A_LOAD, 32'd0);
    bus_wr(A_CTRL, 32'h80);
    pulse(0);
    bus_rd(A_VAL, v); chk("R6 wrap", v, 32'hFFFF_FFFF);
    chk("R6 irq", {31'b0, irq}, 32'h1);
    pulse(0);
    bus_rd(A_VAL, v); chk("R6 continue", v, 32'hFFFF_FFFE);
    bus_wr(A_CLR, 32'hDEAD_BEEF);
    chk("R7 clear any data", {31'b0, irq}, 32'h0);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    bus_wr(A_LOAD, 32'd3);
    bus_wr(A_CTRL, 32'h48);
    pulse(1); pulse(0);
    bus_rd(A_VAL, v); chk("R4 held", v, 32'd3);
    chk("R4 no irq", {31'b0, irq}, 32'h0);
    bus_wr(A_LOAD, 32'd0);
    pulse(1); pulse(0);
    chk("R4 no irq at zero", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear_race();
    logic [31:0] v;
    bus_wr(A_LOAD, 32'd0);
    bus_wr(A_CTRL, 32'hC0);
    @(negedge clk);
    wr_en = 1'b1; addr = A_CLR; wdata = 32'h1; tick_slow = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_slow = 1'b0;
    chk("R7 underflow beats clear", {31'b0, irq}, 32'h1);
    bus_wr(A_CLR, 32'h0);
    chk("R7 later clear", {31'b0, irq}, 32'h0);
    bus_rd(A_VAL, v); chk("R5 reload zero", v, 32'd0);
  endtask

  task automatic t_load_race();
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; addr = A_LOAD; wdata = 32'd7; tick_slow = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_slow = 1'b0;
    bus_rd(A_VAL, v); chk("R10 load wins", v, 32'd7);
    chk("R10 no irq", {31'b0, irq}, 32'h0);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); chk("R8 ctrl mask", v, 32'h0000_00C8);
    bus_rd(A_CLR, v);  chk("R8 clear reads zero", v, 32'h0);
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_w16();
    logic [31:0] v;
    bus_wr(A_LOAD, 32'h0001_2345);
    @(negedge clk); addr = A_VAL; #1;
    chk("R9 truncate 16", rdata_w16, 32'h0000_2345);
    chk("R9 wide keeps all", rdata, 32'h0001_2345);
    bus_wr(A_LOAD, 32'h0);
    bus_wr(A_CTRL, 32'h80);
    pulse(0);
    @(negedge clk); addr = A_VAL; #1;
    chk("R9 wrap 16", rdata_w16, 32'h0000_FFFF);
    chk("R9 irq 16", {31'b0, irq_w16}, 32'h1);
    bus_rd(A_VAL, v); chk("R9 wrap 32", v, 32'hFFFF_FFFF);
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_CLR, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load();
    t_count();
    t_periodic();
    t_freerun();
    t_disabled();
    t_clear_race();
    t_load_race();
    t_readback();
    t_w16();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule